// File: doc/BRIEF.md
# Aperture Address Remapping Table

The block remaps device addresses that fall inside a fixed window of 4 KiB pages. It keeps one entry per page in an internal table. Each entry holds a valid flag and a physical page frame. When translation is on, a lookup whose bytes all sit inside the window takes the frame from its page's entry and keeps its own 12-bit page offset. The block answers every lookup with either a hit or a fault.

Software programs the table indirectly through three registers. The first is a configuration register that switches translation on and off. The second is an entry-address register, which takes a window address and picks the page. The third is an entry-data register, which reads or writes the entry that the entry-address register picks. The window base and the page count are parameters. The lookup path is a single registered stage, and a register write in the same cycle does not affect it.

Top module: `remap_aperture`

## Requirements
- R1: After reset every entry is zero and translation is off. The configuration register reads 0. The entry-address register reads the window base, and every lookup faults.
- R2: A write to byte offset 0x0 sets the enable from bit 0 of the write data. A read at 0x0 returns the enable in bit 0 and zero in bits 31:1.
- R3: A write to byte offset 0x4 with an address A inside the window selects entry (A - base) >> 12. A read at 0x4 returns base + index * 4096.
- R4: A write to offset 0x4 with an address below the base, or above base + count*4096 - 1, is ignored. The selected index does not change.
- R5: A write to byte offset 0x8 stores bit 31 (valid) and bits 30:12 (frame) into the selected entry and discards bits 11:0. A read at 0x8 returns the selected entry with bits 11:0 zero. A read at any other offset returns zero.
- R6: Writing zero to offset 0x8 unmaps the selected page. Its entry reads back as zero, and lookups into that page fault.
- R7: A lookup is presented by raising req_valid for one cycle. rsp_valid is high in exactly the following cycle, and is low after any cycle without a request.
- R8: When translation is on, the request is inside the window and its entry is valid, the response has rsp_hit=1 and rsp_fault=0. rsp_addr is then {0, entry bits 30:12, request bits 11:0}.
- R9: A request faults (rsp_hit=0, rsp_fault=1, rsp_addr=0) when its first byte req_addr or its last byte req_addr+req_len is outside the window.
- R10: A request into a page whose entry has bit 31 clear faults.
- R11: Every request faults while translation is off.
- R12: A lookup presented in the same cycle as a register write uses the table contents and enable as they were before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Device address of the first byte |
| req_len | input | 12 | Byte count minus one |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_fault | output | 1 | Translation refused |
| rsp_addr | output | 32 | Translated physical address, zero on fault |

## Verification
The assertions assume two things about the inputs. First, reg_addr and reg_wdata are stable around the clock edge. Second, the sum of req_addr and req_len does not go past the 32-bit space in a way that matters. The window sits well below the top of the address space, so an overflow would still fail the upper bound check. The stimulus drives every input shortly after a rising edge and holds it through the next one. All request addresses stay within a few pages of the window, and req_len stays within 0 to 4095, so the one-cycle checks on the response always see a defined request from the previous cycle.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam int FRAME_W    = 19;

  localparam logic [3:0] OFF_CFG   = 4'h0;
  localparam logic [3:0] OFF_EADDR = 4'h4;
  localparam logic [3:0] OFF_EDATA = 4'h8;

  typedef struct packed {
    logic               vld;
    logic [FRAME_W-1:0] frame;
  } entry_t;
endpackage

// File: rtl/remap_table.sv
module remap_table
  import remap_pkg::*;
#(
  parameter int PAGE_COUNT = 32,
  parameter int IDX_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  entry_t           wdata,
  input  logic [IDX_W-1:0] ridx_a,
  output entry_t           rdata_a,
  input  logic [IDX_W-1:0] ridx_b,
  output entry_t           rdata_b
);
  entry_t ent_q [PAGE_COUNT];

  for (genvar gi = 0; gi < PAGE_COUNT; gi++) begin : g_ent
    logic ld;
    assign ld = we && (widx == IDX_W'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ent_q[gi] <= '0;
      else if (ld) ent_q[gi] <= wdata;
    end
  end

  always_comb begin
    rdata_a = '0;
    rdata_b = '0;
    for (int i = 0; i < PAGE_COUNT; i++) begin
      if (ridx_a == IDX_W'(i)) rdata_a = ent_q[i];
      if (ridx_b == IDX_W'(i)) rdata_b = ent_q[i];
    end
  end

  AST_UNMAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (we && wdata == '0) |=> (rdata_a == '0 || ridx_a != $past(widx))); // R6
endmodule

// File: rtl/remap_regs.sv
module remap_regs
  import remap_pkg::*;
#(
  parameter logic [31:0] WIN_BASE   = 32'h4000_0000,
  parameter int          PAGE_COUNT = 32,
  parameter int          IDX_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [3:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  entry_t           ent_rd,
  output logic             en,
  output logic [IDX_W-1:0] idx,
  output logic             tab_we,
  output entry_t           tab_wdata
);
  localparam logic [32:0] WIN_LO = {1'b0, WIN_BASE};
  localparam logic [32:0] WIN_HI = WIN_LO + 33'(PAGE_COUNT) * 33'd4096 - 33'd1;

  logic             en_q, en_d, en_ld;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_ld, wr_in_win;
  logic [31:0]      wr_off;

  assign wr_in_win = ({1'b0, reg_wdata} >= WIN_LO) && ({1'b0, reg_wdata} <= WIN_HI);
  assign wr_off    = reg_wdata - WIN_BASE;

  always_comb begin
    en_ld  = reg_we && (reg_addr == OFF_CFG);
    en_d   = reg_wdata[0];
    idx_ld = reg_we && (reg_addr == OFF_EADDR) && wr_in_win;
    idx_d  = wr_off[PAGE_SHIFT +: IDX_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      idx_q <= '0;
    end else begin
      if (en_ld)  en_q  <= en_d;
      if (idx_ld) idx_q <= idx_d;
    end
  end

  assign en        = en_q;
  assign idx       = idx_q;
  assign tab_we    = reg_we && (reg_addr == OFF_EDATA);
  assign tab_wdata = '{vld: reg_wdata[31], frame: reg_wdata[30:PAGE_SHIFT]};

  always_comb begin
    unique case (reg_addr)
      OFF_CFG:   reg_rdata = {31'b0, en_q};
      OFF_EADDR: reg_rdata = WIN_BASE + {{(32-IDX_W-PAGE_SHIFT){1'b0}}, idx_q, {PAGE_SHIFT{1'b0}}};
      OFF_EDATA: reg_rdata = {ent_rd.vld, ent_rd.frame, {PAGE_SHIFT{1'b0}}};
      default:   reg_rdata = '0;
    endcase
  end

  AST_EADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (reg_we && reg_addr == OFF_EADDR && !wr_in_win) |=> $stable(idx_q)); // R4
  AST_CFG_TAKES: assert property (@(posedge clk) disable iff (!rst_n) (reg_we && reg_addr == OFF_CFG) |=> (en_q == $past(reg_wdata[0]))); // R2
endmodule

// File: rtl/remap_lookup.sv
module remap_lookup
  import remap_pkg::*;
#(
  parameter logic [31:0] WIN_BASE   = 32'h4000_0000,
  parameter int          PAGE_COUNT = 32,
  parameter int          IDX_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             req_valid,
  input  logic [31:0]      req_addr,
  input  logic [11:0]      req_len,
  output logic [IDX_W-1:0] lk_idx,
  input  entry_t           lk_ent,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic [31:0]      rsp_addr
);
  localparam logic [32:0] WIN_LO = {1'b0, WIN_BASE};
  localparam logic [32:0] WIN_HI = WIN_LO + 33'(PAGE_COUNT) * 33'd4096 - 33'd1;

  logic [32:0] last_b;
  logic [31:0] off;
  logic        in_win, hit_d, fault_d;
  logic [31:0] addr_d;
  logic        vld_q, hit_q, fault_q;
  logic [31:0] addr_q;

  always_comb begin
    last_b  = {1'b0, req_addr} + {21'b0, req_len};
    in_win  = ({1'b0, req_addr} >= WIN_LO) && (last_b <= WIN_HI);
    off     = req_addr - WIN_BASE;
    lk_idx  = off[PAGE_SHIFT +: IDX_W];
    hit_d   = req_valid && in_win && en && lk_ent.vld;
    fault_d = req_valid && !hit_d;
    addr_d  = hit_d ? {1'b0, lk_ent.frame, req_addr[PAGE_SHIFT-1:0]} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      hit_q   <= 1'b0;
      fault_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      vld_q   <= req_valid;
      hit_q   <= hit_d;
      fault_q <= fault_d;
      addr_q  <= addr_d;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_hit   = hit_q;
  assign rsp_fault = fault_q;
  assign rsp_addr  = addr_q;

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_valid); // R7
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_fault)); // R7
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> (rsp_hit != rsp_fault)); // R8
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> (!rsp_hit || rsp_addr[11:0] == $past(req_addr[11:0]))); // R8
  AST_OFF_FAULTS: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && !en) |=> rsp_fault); // R11
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rsp_fault |-> (rsp_addr == '0)); // R9
endmodule

// File: rtl/remap_aperture.sv
module remap_aperture
  import remap_pkg::*;
#(
  parameter logic [31:0] WIN_BASE   = 32'h4000_0000,
  parameter int          PAGE_COUNT = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic [11:0] req_len,
  output logic        rsp_valid,
  output logic        rsp_hit,
  output logic        rsp_fault,
  output logic [31:0] rsp_addr
);
  localparam int IDX_W = (PAGE_COUNT > 1) ? $clog2(PAGE_COUNT) : 1;

  logic             en;
  logic [IDX_W-1:0] sel_idx, lk_idx;
  logic             tab_we;
  entry_t           tab_wdata, ent_sel, ent_lk;

  remap_regs #(.WIN_BASE(WIN_BASE), .PAGE_COUNT(PAGE_COUNT), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ent_rd(ent_sel),
    .en(en), .idx(sel_idx), .tab_we(tab_we), .tab_wdata(tab_wdata)
  );

  remap_table #(.PAGE_COUNT(PAGE_COUNT), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n), .we(tab_we), .widx(sel_idx), .wdata(tab_wdata),
    .ridx_a(sel_idx), .rdata_a(ent_sel), .ridx_b(lk_idx), .rdata_b(ent_lk)
  );

  remap_lookup #(.WIN_BASE(WIN_BASE), .PAGE_COUNT(PAGE_COUNT), .IDX_W(IDX_W)) u_lookup (
    .clk(clk), .rst_n(rst_n), .en(en), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .lk_idx(lk_idx), .lk_ent(ent_lk), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_addr(rsp_addr)
  );
endmodule

// File: tb/remap_aperture_test.sv
`timescale 1ns/1ps
module remap_aperture_test;
  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam int          PC   = 32;
  localparam longint      LO   = longint'(BASE);
  localparam longint      HI   = LO + PC * 4096 - 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [11:0] req_len;
  logic        rsp_valid, rsp_hit, rsp_fault;
  logic [31:0] rsp_addr;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic        m_en;
  int          m_idx;
  logic [31:0] m_tab [PC];

  always #4 clk = ~clk;

  remap_aperture #(.WIN_BASE(BASE), .PAGE_COUNT(PC)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_len(req_len), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_addr(rsp_addr)
  );

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      4'h0:    return {31'b0, m_en};
      4'h4:    return BASE + 32'(m_idx) * 32'd4096;
      4'h8:    return m_tab[m_idx];
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [34:0] act, input logic [34:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag);
    logic ev, eh, ef;
    logic [31:0] ea;
    longint first, last;
    int li;
    @(posedge clk);
    ev = req_valid; eh = 0; ef = 0; ea = 0;
    if (req_valid) begin
      first = longint'(req_addr);
      last  = first + longint'(req_len);
      li    = int'((first - LO) >>> 12);
      if (first >= LO && last <= HI && m_en && m_tab[li][31]) begin
        eh = 1; ea = {1'b0, m_tab[li][30:12], req_addr[11:0]};
      end else ef = 1;
    end
    if (reg_we) begin
      case (reg_addr)
        4'h0: m_en = reg_wdata[0];
        4'h4: if (longint'(reg_wdata) >= LO && longint'(reg_wdata) <= HI)
                m_idx = int'((longint'(reg_wdata) - LO) >>> 12);
        4'h8: m_tab[m_idx] = reg_wdata & 32'hFFFF_F000;
        default: ;
      endcase
    end
    #1;
    check({tag, " rsp"}, {rsp_valid, rsp_hit, rsp_fault, rsp_addr}, {ev, eh, ef, ea});
    check({tag, " rdata"}, {3'b0, reg_rdata}, {3'b0, m_read(reg_addr)});
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    cyc(tag);
    reg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    reg_addr = a;
    cyc(tag);
  endtask

  task automatic look(input logic [31:0] a, input logic [11:0] l, input string tag);
    req_valid = 1; req_addr = a; req_len = l;
    cyc(tag);
    req_valid = 0;
    cyc(tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    req_valid = 0; req_addr = 0; req_len = 0;
    m_en = 0; m_idx = 0;
    for (int i = 0; i < PC; i++) m_tab[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    rd(4'h0, "R1"); rd(4'h4, "R1"); rd(4'h8, "R1");
    look(BASE + 32'h10, 0, "R1");
    // R11 disabled: map page 0 while off, lookup still faults
    wr(4'h8, 32'h8000_5000, "R11");
    look(BASE + 32'h20, 0, "R11");
    // R2 enable and readback
    wr(4'h0, 32'hFFFF_FFFF, "R2"); rd(4'h0, "R2");
    look(BASE + 32'h20, 0, "R8");
    // R3 select page 3, R5 write with low bits set
    wr(4'h4, BASE + 32'h3ABC, "R3"); rd(4'h4, "R3");
    wr(4'h8, 32'h8123_4ABC, "R5"); rd(4'h8, "R5"); rd(4'hC, "R5");
    // R4 out-of-window selects ignored
    wr(4'h4, BASE - 32'h1000, "R4"); rd(4'h4, "R4");
    wr(4'h4, BASE + PC * 4096, "R4"); rd(4'h4, "R4"); rd(4'h8, "R4");
    // R8 hit
    look(BASE + 32'h3ABC, 12'h543, "R8");
    // R9 window edges
    look(BASE - 32'h1, 0, "R9");
    wr(4'h4, BASE + 32'h1F000, "R3");
    wr(4'h8, 32'hC000_0000, "R5");
    look(BASE + 32'h1FFF0, 12'hF, "R9");
    look(BASE + 32'h1FFF0, 12'h10, "R9");
    look(BASE + 32'h1F000, 12'hFFF, "R9");
    // R10 invalid entries
    look(BASE + 32'h7000, 0, "R10");
    wr(4'h4, BASE + 32'h9000, "R3");
    wr(4'h8, 32'h7FFF_F000, "R10");
    look(BASE + 32'h9123, 0, "R10");
    // R6 unmap page 3
    wr(4'h4, BASE + 32'h3000, "R6");
    wr(4'h8, 32'h0, "R6"); rd(4'h8, "R6");
    look(BASE + 32'h3004, 0, "R6");
    // R12 same-cycle write and lookup
    wr(4'h4, BASE + 32'h5000, "R12");
    req_valid = 1; req_addr = BASE + 32'h5010; req_len = 0;
    wr(4'h8, 32'h8765_4000, "R12");
    req_valid = 0; cyc("R12");
    look(BASE + 32'h5010, 0, "R12");
    req_valid = 1; req_addr = BASE + 32'h5FFF; req_len = 0;
    wr(4'h0, 32'h0, "R12");
    req_valid = 0; cyc("R12");
    look(BASE + 32'h5010, 0, "R11");
    wr(4'h0, 32'h1, "R2");
    // R8 patterned sweep
    for (int p = 0; p < PC; p += 3) begin
      wr(4'h4, BASE + 32'(p) * 32'd4096 + 32'h77, "R3");
      wr(4'h8, 32'h8000_0000 | (32'(p * 7 + 1) << 12), "R5");
    end
    for (int p = 0; p < PC; p++) begin
      look(BASE + 32'(p) * 32'd4096 + 32'(p * 13), 12'(p), "R8");
    end
    // R7 back-to-back requests
    for (int p = 0; p < 6; p++) begin
      req_valid = 1; req_addr = BASE + 32'(p) * 32'd4096 + 32'h8; req_len = 0;
      cyc("R7");
    end
    req_valid = 0; cyc("R7"); cyc("R7");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule